// File: doc/BRIEF.md
# Row-Sequenced Time-to-Threshold Converter

This block drives the row control lines of a pulse-width-modulated pixel array and converts each pixel's time-to-threshold into a digital code. The array has `ROWS` rows and `COLS` columns, and rows are handled one at a time. For each row the block first holds that row's precharge line high. It then drops the precharge line and raises the row's readout line, which starts integration. From that cycle on, one converter at the foot of each column counts clock cycles until the column's comparator output toggles. A bright pixel toggles early and gives a small code. A dark pixel may never toggle and gives the saturation code.

After every column of the row holds a code, the codes leave through a valid/ready stream in column order. The next row's precharge starts only once the last code of the row has been accepted. A one-cycle frame-start pulse latches the precharge length and the integration limit, then begins row 0. A one-cycle frame-done pulse follows the final code of the last row.

Top module: `tth_array_conv`

## Requirements
- R1: After reset and while no frame is running, every row precharge line and every row readout line is low, `codeValid` is low and `frameDone` is low. Column input toggles while idle produce no code.
- R2: Rows are visited in order 0 to ROWS-1. During a row's precharge phase only that row's `rowReset` bit is high, for exactly L+1 cycles, where L is the latched precharge length.
- R3: Integration starts in the cycle right after the row's precharge phase ends. During integration only that row's `rowEnable` bit is high and every `rowReset` bit is low.
- R4: Take cycle 0 as the first cycle in which `rowEnable` is high. If a column input changes level in cycle t, that column's code is t+2. The two extra cycles come from a two-stage synchronizer.
- R5: Only the first level change of a column within a row sets its code. Later changes in the same row leave the code unchanged.
- R6: A column whose code would exceed the latched integration limit M receives the all-ones code (255 at CW=8). A column whose code equals M exactly keeps M.
- R7: Integration ends after the cycle in which the last column captures, or after the cycle in which the count reaches M, whichever comes first. `rowEnable` is therefore high for c+1 cycles, where c is the last capture count, or for M+1 cycles.
- R8: A row's codes appear on `codeData` starting with column 0 and moving up by one column on each accepted transfer (`codeValid` and `codeReady` both high). While `codeReady` is low, the valid code stays on `codeData` unchanged.
- R9: While codes of a row are pending, every row line is low. The next row's precharge starts only after the row's last code is accepted.
- R10: `frameDone` is high for exactly one cycle, in the cycle after the last code of row ROWS-1 is accepted. The block is then idle.
- R11: `cfgResetLen` and `cfgMaxInt` are sampled only when `frameStart` arrives while idle. A `frameStart` pulse or a configuration change during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Pulse that begins a frame when idle |
| cfgResetLen | input | RW | Precharge length L; phase lasts L+1 cycles |
| cfgMaxInt | input | CW | Integration limit M in cycles |
| pixOut | input | COLS | Comparator output of each column line |
| rowReset | output | ROWS | Per-row precharge line |
| rowEnable | output | ROWS | Per-row readout enable line |
| codeValid | output | 1 | Code stream valid |
| codeReady | input | 1 | Code stream ready |
| codeData | output | CW | Time-to-threshold code |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The sequencer state is visible on the row lines at once. A wrong phase counter changes the number of cycles a row's precharge or readout line stays high within the same row. A wrong row index lights the wrong bit or breaks the one-hot rule in the first cycle it is wrong. A corrupted capture flag or time counter only shows up when that row's codes are streamed out, as an off-by-N or saturated code at the matching column position. A serializer index error shifts codes between columns or delays the frame-done pulse by one transfer or more.

// File: rtl/tth_pkg.sv
package tth_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RESET,
    PH_INTEG,
    PH_DRAIN
  } phase_t;

  // strobes from the row sequencer to the column datapath
  typedef struct packed {
    logic clearCols;  // last precharge cycle: re-arm every column
    logic integ;      // integration cycle: columns may capture
    logic saturate;   // final integration cycle: force pending columns
    logic drain;      // codes are being streamed out
  } colCtl_t;

endpackage

// File: rtl/tth_ctrl.sv
module tth_ctrl
  import tth_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int CW   = 8,
  parameter int RW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic [RW-1:0]   cfgResetLen,
  input  logic [CW-1:0]   cfgMaxInt,
  input  logic            allDone,
  input  logic            lastTaken,
  output colCtl_t         ctl,
  output logic [CW-1:0]   timeNow,
  output logic [ROWS-1:0] rowReset,
  output logic [ROWS-1:0] rowEnable,
  output logic            frameDone
);

  localparam int PCW = (CW > RW) ? CW : RW;
  localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1;

  phase_t         phase;
  logic [PCW-1:0] phaseCnt;
  logic [RW-1:0]  rstLenQ;
  logic [CW-1:0]  maxIntQ;
  logic [RIW-1:0] rowIdx;

  logic rstEnd;
  logic intEnd;

  assign rstEnd = (phaseCnt == PCW'(rstLenQ));
  assign intEnd = (phaseCnt == PCW'(maxIntQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      phaseCnt  <= '0;
      rstLenQ   <= '0;
      maxIntQ   <= '0;
      rowIdx    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (frameStart) begin
            rstLenQ  <= cfgResetLen;
            maxIntQ  <= cfgMaxInt;
            rowIdx   <= '0;
            phaseCnt <= '0;
            phase    <= PH_RESET;
          end
        end
        PH_RESET: begin
          if (rstEnd) begin
            phaseCnt <= '0;
            phase    <= PH_INTEG;
          end else begin
            phaseCnt <= phaseCnt + PCW'(1);
          end
        end
        PH_INTEG: begin
          if (allDone || intEnd) begin
            phaseCnt <= '0;
            phase    <= PH_DRAIN;
          end else begin
            phaseCnt <= phaseCnt + PCW'(1);
          end
        end
        PH_DRAIN: begin
          if (lastTaken) begin
            if (rowIdx == RIW'(ROWS - 1)) begin
              phase     <= PH_IDLE;
              frameDone <= 1'b1;
            end else begin
              rowIdx <= rowIdx + RIW'(1);
              phase  <= PH_RESET;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign timeNow       = phaseCnt[CW-1:0];
  assign ctl.clearCols = (phase == PH_RESET) && rstEnd;
  assign ctl.integ     = (phase == PH_INTEG);
  assign ctl.saturate  = (phase == PH_INTEG) && intEnd;
  assign ctl.drain     = (phase == PH_DRAIN);

  for (genvar r = 0; r < ROWS; r++) begin : g_rowLine
    assign rowReset[r]  = (phase == PH_RESET) && (rowIdx == RIW'(r));
    assign rowEnable[r] = (phase == PH_INTEG) && (rowIdx == RIW'(r));
  end

endmodule

// File: rtl/tth_columns.sv
module tth_columns
  import tth_pkg::*;
#(
  parameter int COLS = 4,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  colCtl_t         ctl,
  input  logic [CW-1:0]   timeNow,
  input  logic [COLS-1:0] pixIn,
  input  logic            codeReady,
  output logic            allDone,
  output logic            lastTaken,
  output logic            codeValid,
  output logic [CW-1:0]   codeData
);

  localparam int CIW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [COLS-1:0][CW-1:0] codeBus;
  logic [COLS-1:0]         doneVec;
  logic [CIW-1:0]          outIdx;
  logic                    taken;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic          syncA;
    logic          syncB;
    logic          prevB;
    logic          capQ;
    logic [CW-1:0] codeQ;
    logic          toggle;

    assign toggle = syncB ^ prevB;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        prevB <= 1'b0;
        capQ  <= 1'b0;
        codeQ <= '0;
      end else begin
        syncA <= pixIn[c];
        syncB <= syncA;
        prevB <= syncB;
        if (ctl.clearCols) begin
          capQ <= 1'b0;
        end else if (ctl.integ && !capQ) begin
          if (toggle) begin
            codeQ <= timeNow;
            capQ  <= 1'b1;
          end else if (ctl.saturate) begin
            codeQ <= '1;
            capQ  <= 1'b1;
          end
        end
      end
    end

    assign doneVec[c] = capQ | toggle;
    assign codeBus[c] = codeQ;
  end

  assign allDone   = &doneVec;
  assign codeValid = ctl.drain;
  assign codeData  = codeBus[outIdx];
  assign taken     = ctl.drain && codeReady;
  assign lastTaken = taken && (outIdx == CIW'(COLS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outIdx <= '0;
    end else if (taken) begin
      outIdx <= lastTaken ? '0 : outIdx + CIW'(1);
    end
  end

endmodule

// File: rtl/tth_array_conv.sv
module tth_array_conv
  import tth_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int CW   = 8,
  parameter int RW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic [RW-1:0]   cfgResetLen,
  input  logic [CW-1:0]   cfgMaxInt,
  input  logic [COLS-1:0] pixOut,
  output logic [ROWS-1:0] rowReset,
  output logic [ROWS-1:0] rowEnable,
  output logic            codeValid,
  input  logic            codeReady,
  output logic [CW-1:0]   codeData,
  output logic            frameDone
);

  colCtl_t       ctl;
  logic [CW-1:0] timeNow;
  logic          allDone;
  logic          lastTaken;

  tth_ctrl #(.ROWS(ROWS), .CW(CW), .RW(RW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameStart  (frameStart),
    .cfgResetLen (cfgResetLen),
    .cfgMaxInt   (cfgMaxInt),
    .allDone     (allDone),
    .lastTaken   (lastTaken),
    .ctl         (ctl),
    .timeNow     (timeNow),
    .rowReset    (rowReset),
    .rowEnable   (rowEnable),
    .frameDone   (frameDone)
  );

  tth_columns #(.COLS(COLS), .CW(CW)) u_cols (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .timeNow   (timeNow),
    .pixIn     (pixOut),
    .codeReady (codeReady),
    .allDone   (allDone),
    .lastTaken (lastTaken),
    .codeValid (codeValid),
    .codeData  (codeData)
  );

endmodule

// File: rtl/tth_array_conv_chk.sv
module tth_array_conv_chk #(
  parameter int ROWS = 4,
  parameter int CW   = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [ROWS-1:0] rowReset,
  input logic [ROWS-1:0] rowEnable,
  input logic            codeValid,
  input logic            codeReady,
  input logic [CW-1:0]   codeData,
  input logic            frameDone
);

  assert_one_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowReset));

  assert_one_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowEnable));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !((|rowReset) && (|rowEnable)));

  assert_enable_after_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((|rowEnable) && !$past(|rowEnable)) |-> ($past(rowReset) == rowEnable));

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !codeReady) |=> (codeValid && $stable(codeData)));

  assert_quiet_drain_R9: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> ((rowReset == '0) && (rowEnable == '0)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!codeValid && (rowReset == '0) && (rowEnable == '0)));

endmodule

bind tth_array_conv tth_array_conv_chk #(.ROWS(ROWS), .CW(CW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rowReset  (rowReset),
  .rowEnable (rowEnable),
  .codeValid (codeValid),
  .codeReady (codeReady),
  .codeData  (codeData),
  .frameDone (frameDone)
);

// File: tb/sim_tth_array_conv.sv
`timescale 1ns/1ps
module sim_tth_array_conv;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int CW   = 8;
  localparam int RW   = 8;
  localparam int SAT  = 255;

  logic            clk = 1'b0;
  logic            rstN;
  logic            frameStart;
  logic [RW-1:0]   cfgResetLen;
  logic [CW-1:0]   cfgMaxInt;
  logic [COLS-1:0] pixOut;
  logic [ROWS-1:0] rowReset;
  logic [ROWS-1:0] rowEnable;
  logic            codeValid;
  logic            codeReady;
  logic [CW-1:0]   codeData;
  logic            frameDone;

  always #4 clk = ~clk;

  tth_array_conv #(.ROWS(ROWS), .COLS(COLS), .CW(CW), .RW(RW)) u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .cfgResetLen(cfgResetLen),
    .cfgMaxInt(cfgMaxInt), .pixOut(pixOut), .rowReset(rowReset), .rowEnable(rowEnable),
    .codeValid(codeValid), .codeReady(codeReady), .codeData(codeData), .frameDone(frameDone)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fdCount = 0;
  int expQ[$];
  string tagQ[$];
  bit stallPrev = 1'b0;
  logic [CW-1:0] dataPrev;
  int dly[ROWS][COLS];
  int dbl[ROWS][COLS];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: drives ready pattern, pops scoreboard on each transfer
  always @(negedge clk) begin : monitor
    int e;
    string t;
    cyc++;
    if (frameDone) fdCount++;
    codeReady = ((cyc % 3) != 1);
    if (stallPrev)
      check(codeValid && (codeData == dataPrev), "R8 stalled code held", codeData, dataPrev);
    if (codeValid) begin
      check((rowReset == '0) && (rowEnable == '0), "R9 row lines quiet while draining",
            {rowReset, rowEnable}, 0);
      if (codeReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected code", codeData, -1);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(codeData == e, t, codeData, e);
        end
      end
    end
    stallPrev = codeValid && !codeReady;
    dataPrev  = codeData;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_frame(input int L, input int M, input bit midStart);
    int fd0, rc, d, mx, expEn, w;
    bit allCap, first;
    string tg;
    fd0 = fdCount;
    tg = midStart ? "R2 R11 precharge length" : "R2 precharge length";
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (dly[r][c] >= 0 && dly[r][c] + 2 <= M) expQ.push_back(dly[r][c] + 2);
        else expQ.push_back(SAT);
        tagQ.push_back("R4 R5 R6 R8 code");
      end
    @(negedge clk);
    cfgResetLen = RW'(L);
    cfgMaxInt   = CW'(M);
    frameStart  = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      rc = 0;
      first = 1'b1;
      while (!rowEnable[r]) begin
        if (rowReset[r]) rc++;
        if (midStart && r == 1 && first) begin
          cfgResetLen = RW'(L + 5);
          cfgMaxInt   = CW'(M + 9);
          frameStart  = 1'b1;
        end else begin
          frameStart = 1'b0;
        end
        first = 1'b0;
        @(negedge clk);
      end
      frameStart = 1'b0;
      check(rc == L + 1, tg, rc, L + 1);
      check(rowReset == '0 && rowEnable == ROWS'(1 << r), "R3 only this row enabled",
            rowEnable, 1 << r);
      allCap = 1'b1;
      mx = 0;
      for (int c = 0; c < COLS; c++) begin
        if (dly[r][c] < 0 || dly[r][c] + 2 > M) allCap = 1'b0;
        else if (dly[r][c] + 2 > mx) mx = dly[r][c] + 2;
      end
      expEn = allCap ? mx + 1 : M + 1;
      d = 0;
      while (rowEnable[r]) begin
        for (int c = 0; c < COLS; c++)
          if (dly[r][c] == d || dbl[r][c] == d) pixOut[c] = ~pixOut[c];
        d++;
        @(negedge clk);
      end
      check(d == expEn, "R7 integration length", d, expEn);
    end
    w = 0;
    while (fdCount == fd0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(fdCount == fd0 + 1, "R10 frame done seen", fdCount - fd0, 1);
    check(expQ.size() == 0, "R8 all codes delivered", expQ.size(), 0);
    repeat (5) @(negedge clk);
    check(fdCount == fd0 + 1, "R10 single done pulse", fdCount - fd0, 1);
    check(rowReset == '0 && rowEnable == '0 && !codeValid, "R10 idle after frame",
          {rowReset, rowEnable, codeValid}, 0);
  endtask

  initial begin
    rstN = 1'b0;
    frameStart = 1'b0;
    cfgResetLen = '0;
    cfgMaxInt = '0;
    pixOut = '0;
    repeat (3) @(negedge clk);
    check(rowReset == '0 && rowEnable == '0 && !codeValid && !frameDone,
          "R1 outputs low in reset", {rowReset, rowEnable}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    pixOut = 4'b1010;
    repeat (6) @(negedge clk);
    check(!codeValid && rowReset == '0 && rowEnable == '0, "R1 idle ignores column toggles",
          codeValid, 0);
    check(fdCount == 0, "R1 no done while idle", fdCount, 0);

    // frame A: mixed timing, double toggles, exact-limit capture
    dly = '{'{0, 5, 1, 9}, '{3, 3, 3, 3}, '{-1, 4, 18, 19}, '{2, 7, 0, 11}};
    dbl = '{'{-1, 6, -1, -1}, '{-1, -1, -1, 4}, '{-1, -1, -1, -1}, '{5, -1, 3, -1}};
    run_frame(3, 20, 1'b0);

    // frame B: one-cycle precharge, short limit, frameStart mid-frame
    dly = '{'{0, 1, 2, 3}, '{4, 5, -1, 0}, '{-1, -1, -1, -1}, '{1, 1, 2, 2}};
    dbl = '{'{-1, -1, -1, -1}, '{-1, -1, -1, -1}, '{-1, -1, -1, -1}, '{2, -1, 3, -1}};
    run_frame(0, 6, 1'b1);

    // frame C: zero integration limit saturates everything
    dly = '{'{0, 0, -1, -1}, '{-1, -1, -1, -1}, '{-1, -1, -1, -1}, '{-1, -1, -1, -1}};
    dbl = '{'{-1, -1, -1, -1}, '{-1, -1, -1, -1}, '{-1, -1, -1, -1}, '{-1, -1, -1, -1}};
    run_frame(1, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule